// File: doc/BRIEF.md
# Weekday Clock Core with Hourly Chime

This block keeps time of week for a digital clock. A one-pulse-per-second enable advances a chain of fields: seconds and minutes as two BCD digits each (00 to 59), hours as two BCD digits (00 to 23), and a weekday number from 1 (Monday) to 7. All counting happens on the system clock. The second tick and the set keys act only as enables, so no key ever gates a clock.

Four active-low key inputs, already debounced, set the clock. Each one steps its own field by one for every clock cycle it is held low. A key step wraps its field but never carries into the next field up. When a key step and a natural carry reach the same field in the same cycle, the field moves once.

A small state machine drives the hourly chime. It has two states. CHIME_IDLE moves to CHIME_ACTIVE on the ARM transition, taken when minutes and seconds read 59:55. CHIME_ACTIVE returns to CHIME_IDLE on the CLEAR transition, taken when minutes and seconds read 00:00. Each transition takes effect one clock after the time shows the trigger value. In CHIME_ACTIVE the LED follows the blink input. In CHIME_IDLE the LED is off.

Top module: `weekday_clock_core`

## Requirements
- R1: After a synchronous reset the outputs read weekday 1, 00:00:00, and the chime LED is off.
- R2: Seconds count 00 to 59 in BCD. A tick at 59 gives 00 and carries one step into minutes in the same clock edge.
- R3: Minutes count 00 to 59 in BCD. A carry arriving at 59 gives 00 and carries one step into hours.
- R4: Hours count 00 to 23 in BCD. A carry arriving at 23 gives 00 and carries one step into the weekday.
- R5: The weekday counts 1 (Monday) up to 7 and then returns to 1. It never reads 0.
- R6: Each clock cycle in which a key input is low steps that key's field once, with the field's normal wrap. A key step never carries into a higher field.
- R7: If a key step and a natural step reach the same field in one cycle, the field advances by exactly one.
- R8: The chime becomes active one clock after minutes:seconds read 59:55. It becomes inactive one clock after they read 00:00. While active, chime_led equals blink_phase. Otherwise chime_led is 0.
- R9: The seconds and minutes tens digits never exceed 5, and the hours tens digit never exceeds 2.
- R10: In a cycle with no tick and no key low, every time output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle enable, once per second |
| blink_phase | input | 1 | Blink waveform passed to the LED while the chime is active |
| key_day_n | input | 1 | Weekday set key, active low |
| key_hr_n | input | 1 | Hour set key, active low |
| key_min_n | input | 1 | Minute set key, active low |
| key_sec_n | input | 1 | Second set key, active low |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_ones | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| weekday | output | 4 | Day of week, 1 = Monday through 7 |
| chime_led | output | 1 | Hourly chime indicator |

## Verification
The bench targets the full carry ripple from 23:59:59 on day 7, which must land on Monday 00:00:00 in one edge. A design that wraps hours at 24, or lets the weekday reach 0 or 8, fails this check at once. Key wraps at 59 and 23 must leave the next field alone, and a leaked carry would show up there as a changed minute or weekday. A key pressed in the same cycle as a natural carry into the same field must give a single step, and a design that adds the two would skip a value. The chime is checked just before 59:55, during the window with blink high and with blink low, and after 00:00. This exposes an off-by-one window, an LED lit outside the window, or a chime that never clears.

// File: rtl/clk_core_pkg.sv
package clk_core_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic {
        CHIME_IDLE   = 1'b0,
        CHIME_ACTIVE = 1'b1
    } chime_state_e;

endpackage

// File: rtl/bcd_pair_ctr.sv
module bcd_pair_ctr #(
    parameter int DW       = 4,
    parameter int TENS_TOP = 5,
    parameter int ONES_TOP = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nat_adv,
    input  logic          key_adv,
    output logic [DW-1:0] tens,
    output logic [DW-1:0] ones,
    output logic          carry_out
);
    localparam logic [DW-1:0] TENS_TOP_V = DW'(TENS_TOP);
    localparam logic [DW-1:0] ONES_TOP_V = DW'(ONES_TOP);
    localparam logic [DW-1:0] NINE_V     = DW'(9);
    localparam logic [DW-1:0] ONE_V      = DW'(1);

    logic at_top;
    logic step;

    assign at_top    = (tens == TENS_TOP_V) && (ones == ONES_TOP_V);
    assign step      = nat_adv | key_adv;
    assign carry_out = nat_adv & at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            tens <= '0;
            ones <= '0;
        end else if (step) begin
            if (at_top) begin
                tens <= '0;
                ones <= '0;
            end else if (ones == NINE_V) begin
                tens <= tens + ONE_V;
                ones <= '0;
            end else begin
                ones <= ones + ONE_V;
            end
        end
    end

    // R9: tens digit bounded
    a_r9_tens_bound: assert property (@(posedge clk) disable iff (rst)
        tens <= TENS_TOP_V);

    // R2/R3/R4/R6: step at top value wraps to zero
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        ((nat_adv || key_adv) && at_top) |=> (tens == '0 && ones == '0));

    // R7: simultaneous key and natural step moves the units digit by one
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        (nat_adv && key_adv && !at_top && ones != NINE_V)
        |=> (ones == $past(ones) + ONE_V && tens == $past(tens)));

    // R10: no step, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!nat_adv && !key_adv) |=> $stable({tens, ones}));

endmodule

// File: rtl/weekday_ctr.sv
module weekday_ctr #(
    parameter int DW        = 4,
    parameter int FIRST_DAY = 1,
    parameter int LAST_DAY  = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          nat_adv,
    input  logic          key_adv,
    output logic [DW-1:0] day
);
    localparam logic [DW-1:0] FIRST_V = DW'(FIRST_DAY);
    localparam logic [DW-1:0] LAST_V  = DW'(LAST_DAY);
    localparam logic [DW-1:0] ONE_V   = DW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            day <= FIRST_V;
        end else if (nat_adv || key_adv) begin
            if (day == LAST_V) begin
                day <= FIRST_V;
            end else begin
                day <= day + ONE_V;
            end
        end
    end

    // R5: weekday stays inside its range
    a_r5_in_range: assert property (@(posedge clk) disable iff (rst)
        (day >= FIRST_V) && (day <= LAST_V));

    // R5: last day returns to the first
    a_r5_wrap_first: assert property (@(posedge clk) disable iff (rst)
        ((nat_adv || key_adv) && day == LAST_V) |=> (day == FIRST_V));

endmodule

// File: rtl/chime_fsm.sv
module chime_fsm
    import clk_core_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] min_tens,
    input  logic [DW-1:0] min_ones,
    input  logic [DW-1:0] sec_tens,
    input  logic [DW-1:0] sec_ones,
    input  logic          blink_phase,
    output logic          chime_led
);
    localparam logic [DW-1:0] FIVE_V = DW'(5);
    localparam logic [DW-1:0] NINE_V = DW'(9);

    chime_state_e state_q;
    chime_state_e state_d;
    logic         arm_hit;
    logic         clear_hit;

    assign arm_hit   = (min_tens == FIVE_V) && (min_ones == NINE_V) &&
                       (sec_tens == FIVE_V) && (sec_ones == FIVE_V);
    assign clear_hit = (min_tens == '0) && (min_ones == '0) &&
                       (sec_tens == '0) && (sec_ones == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHIME_IDLE:   if (arm_hit)   state_d = CHIME_ACTIVE;
            CHIME_ACTIVE: if (clear_hit) state_d = CHIME_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CHIME_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            CHIME_IDLE:   chime_led = 1'b0;
            CHIME_ACTIVE: chime_led = blink_phase;
        endcase
    end

    // R8: ARM transition
    a_r8_arm: assert property (@(posedge clk) disable iff (rst)
        (state_q == CHIME_IDLE && arm_hit) |=> (state_q == CHIME_ACTIVE));

    // R8: CLEAR transition
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (state_q == CHIME_ACTIVE && clear_hit) |=> (state_q == CHIME_IDLE));

    // R8: idle keeps LED dark for the next cycle unless armed
    a_r8_dark: assert property (@(posedge clk) disable iff (rst)
        (state_q == CHIME_IDLE && !arm_hit) |=> !chime_led);

endmodule

// File: rtl/weekday_clock_core.sv
module weekday_clock_core
    import clk_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       blink_phase,
    input  logic       key_day_n,
    input  logic       key_hr_n,
    input  logic       key_min_n,
    input  logic       key_sec_n,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] hr_tens,
    output logic [3:0] weekday,
    output logic       chime_led
);
    logic sec_carry;
    logic min_carry;
    logic hr_carry;

    bcd_pair_ctr #(.DW(DIGIT_W), .TENS_TOP(5), .ONES_TOP(9)) u_sec (
        .clk       (clk),
        .rst       (rst),
        .nat_adv   (sec_tick),
        .key_adv   (!key_sec_n),
        .tens      (sec_tens),
        .ones      (sec_ones),
        .carry_out (sec_carry)
    );

    bcd_pair_ctr #(.DW(DIGIT_W), .TENS_TOP(5), .ONES_TOP(9)) u_min (
        .clk       (clk),
        .rst       (rst),
        .nat_adv   (sec_carry),
        .key_adv   (!key_min_n),
        .tens      (min_tens),
        .ones      (min_ones),
        .carry_out (min_carry)
    );

    bcd_pair_ctr #(.DW(DIGIT_W), .TENS_TOP(2), .ONES_TOP(3)) u_hr (
        .clk       (clk),
        .rst       (rst),
        .nat_adv   (min_carry),
        .key_adv   (!key_hr_n),
        .tens      (hr_tens),
        .ones      (hr_ones),
        .carry_out (hr_carry)
    );

    weekday_ctr #(.DW(DIGIT_W), .FIRST_DAY(1), .LAST_DAY(7)) u_day (
        .clk     (clk),
        .rst     (rst),
        .nat_adv (hr_carry),
        .key_adv (!key_day_n),
        .day     (weekday)
    );

    chime_fsm #(.DW(DIGIT_W)) u_chime (
        .clk         (clk),
        .rst         (rst),
        .min_tens    (min_tens),
        .min_ones    (min_ones),
        .sec_tens    (sec_tens),
        .sec_ones    (sec_ones),
        .blink_phase (blink_phase),
        .chime_led   (chime_led)
    );

    // R6: a minute key alone never moves the hour field
    a_r6_min_key_no_carry: assert property (@(posedge clk) disable iff (rst)
        (!key_min_n && !sec_carry && key_hr_n) |=> $stable({hr_tens, hr_ones}));

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (weekday == 4'd1 && hr_tens == 4'd0 && hr_ones == 4'd0 &&
                 min_tens == 4'd0 && min_ones == 4'd0 &&
                 sec_tens == 4'd0 && sec_ones == 4'd0 && !chime_led));

endmodule

// File: tb/weekday_clock_core_bench.sv
`timescale 1ns/1ps
module weekday_clock_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       blink_phase = 1'b1;
    logic       key_day_n = 1'b1;
    logic       key_hr_n = 1'b1;
    logic       key_min_n = 1'b1;
    logic       key_sec_n = 1'b1;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens, weekday;
    logic       chime_led;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    weekday_clock_core u_weekday_clock_core (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .blink_phase(blink_phase),
        .key_day_n(key_day_n), .key_hr_n(key_hr_n), .key_min_n(key_min_n),
        .key_sec_n(key_sec_n), .sec_ones(sec_ones), .sec_tens(sec_tens),
        .min_ones(min_ones), .min_tens(min_tens), .hr_ones(hr_ones),
        .hr_tens(hr_tens), .weekday(weekday), .chime_led(chime_led)
    );

    // stimulus bits {tick, day key, hour key, minute key, second key} (1 = act)
    // expected nibbles {weekday, hr tens, hr ones, min tens, min ones, sec tens, sec ones}
    localparam logic [32:0] VEC [0:7] = '{
        {5'b10000, 28'h1000001},   // R2 tick
        {5'b00001, 28'h1000002},   // R6 second key
        {5'b00010, 28'h1000102},   // R6 minute key
        {5'b00100, 28'h1010102},   // R6 hour key
        {5'b01000, 28'h2010102},   // R6 day key
        {5'b10001, 28'h2010103},   // R7 tick and second key together
        {5'b00000, 28'h2010103},   // R10 idle
        {5'b10010, 28'h2010204}    // R2 tick with R6 minute key
    };

    task automatic cyc(input logic [4:0] s);
        @(negedge clk);
        sec_tick  = s[4];
        key_day_n = !s[3];
        key_hr_n  = !s[2];
        key_min_n = !s[1];
        key_sec_n = !s[0];
        @(negedge clk);
        sec_tick  = 1'b0;
        key_day_n = 1'b1;
        key_hr_n  = 1'b1;
        key_min_n = 1'b1;
        key_sec_n = 1'b1;
    endtask

    task automatic press(input logic [4:0] s, input int n);
        for (int i = 0; i < n; i++) cyc(s);
    endtask

    task automatic check_time(input string req, input logic [27:0] exp);
        logic [27:0] act;
        act = {weekday, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: time actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_led(input string req, input logic exp);
        n_tests++;
        if (chime_led !== exp) begin
            n_fail++;
            $display("FAIL %s: chime_led actual %b expected %b", req, chime_led, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_time("R1", 28'h1000000);
        check_led("R1", 1'b0);

        for (int v = 0; v < 8; v++) begin
            cyc(VEC[v][32:28]);
            check_time("R2/R6/R7/R10 table", VEC[v][27:0]);
        end

        // R2 seconds wrap with carry
        press(5'b00001, 55);
        check_time("R2", 28'h2010259);
        cyc(5'b10000);
        check_time("R2", 28'h2010300);

        // R6 second key wrap, no carry
        press(5'b00001, 59);
        cyc(5'b00001);
        check_time("R6", 28'h2010300);

        // R6 minute key wrap, no carry
        press(5'b00010, 56);
        check_time("R6", 28'h2015900);
        cyc(5'b00010);
        check_time("R6", 28'h2010000);

        // R3 minute carry into hours
        press(5'b00010, 59);
        press(5'b00001, 59);
        cyc(5'b10000);
        check_time("R3", 28'h2020000);

        // R4 hour carry into weekday
        press(5'b00100, 21);
        press(5'b00010, 59);
        press(5'b00001, 59);
        check_time("R4", 28'h2235959);
        check_led("R8", 1'b1);
        cyc(5'b10000);
        check_time("R4", 28'h3000000);
        cyc(5'b00000);
        check_led("R8", 1'b0);

        // R6 hour key wrap, no carry into weekday
        press(5'b00100, 23);
        cyc(5'b00100);
        check_time("R6", 28'h3000000);

        // R5 weekday key wrap
        press(5'b01000, 4);
        check_time("R5", 28'h7000000);
        cyc(5'b01000);
        check_time("R5", 28'h1000000);

        // R4/R5 full ripple from day 7 23:59:59
        press(5'b01000, 6);
        press(5'b00100, 23);
        press(5'b00010, 59);
        press(5'b00001, 59);
        check_time("R9", 28'h7235959);
        cyc(5'b10000);
        check_time("R5", 28'h1000000);

        // R8 chime window
        press(5'b00010, 59);
        press(5'b00001, 54);
        cyc(5'b00000);
        check_led("R8", 1'b0);
        cyc(5'b10000);
        check_time("R8", 28'h1005955);
        cyc(5'b00000);
        check_led("R8", 1'b1);
        blink_phase = 1'b0;
        #1;
        check_led("R8", 1'b0);
        blink_phase = 1'b1;
        press(5'b10000, 4);
        check_time("R8", 28'h1005959);
        check_led("R8", 1'b1);
        cyc(5'b10000);
        check_time("R3", 28'h1010000);
        cyc(5'b00000);
        check_led("R8", 1'b0);

        // R7 minute key with natural carry into minutes
        press(5'b00001, 59);
        cyc(5'b10010);
        check_time("R7", 28'h1010100);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_time("R1", 28'h1000000);
        check_led("R1", 1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule